// File: doc/BRIEF.md
# Sideband-Forced Memory Claim Decoder

This block is the address-phase claim logic of a PCI target that fronts system memory. For every bus transaction it decides whether to assert DEVSEL#. A claim needs a memory read or memory write command, and the latched address must fall inside the system-memory window. By default that window is the upper half of the 32-bit space, from 0x8000_0000 to 0xFFFF_FFFF.

A bridge for a narrow legacy bus cannot drive a full 32-bit address. For that case an active-low sideband input is provided. The bridge pulls it low when it is granted the bus. When the pin is low during the address phase, the claim is made whatever the address bits hold. The only further condition is that the command is a memory command. The override can collide with another target that decodes the same transaction, and the block accepts that risk. Tying the pin high removes the override.

The decision is passed to the memory path as a one-cycle strobe. The strobe carries the captured address, the direction and whether the claim was forced. It is a plain control indication with no back-pressure. The memory path must take it on the cycle it appears, because the bus timing does not wait.

Top module: `mcd_claim_top`

## Requirements
- R1: While reset is active and right after it, devsel_n is high and claim_stb is low.
- R2: The command codes are taken from cbe_n in the address phase: 4'b0110 is a memory read and 4'b0111 is a memory write. With the sideband pin high, the block claims when (address & WIN_MASK) == WIN_BASE. The defaults make bit 31 set mean a hit.
- R3: With the sideband pin high and the address outside the window, no claim is made.
- R4: With legacy_force_n low in the address phase and a memory command, a claim is made for any address, and claim_forced reads 1.
- R5: Commands other than 4'b0110 and 4'b0111 are never claimed, even when legacy_force_n is low. Examples are I/O (4'b0010) and configuration (4'b1010).
- R6: The address phase is the first rising edge that samples frame_n low while the bus was idle. devsel_n goes low at the second rising edge after it, which is medium decode timing.
- R7: Once asserted, devsel_n stays low until a rising edge samples frame_n and irdy_n both high. It goes high at that edge.
- R8: Address, command and sideband state are latched only at the address-phase edge. Changes to ad, cbe_n or legacy_force_n during the data phases have no effect on the decision.
- R9: claim_stb is high for exactly one cycle, on the same edge that drives devsel_n low. During that cycle claim_addr holds the address-phase AD value, and claim_write is 1 for a memory write.
- R10: If the bus returns to idle before the decision edge, meaning frame_n and irdy_n are both sampled high at either of the two edges after the address phase, no claim is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command / byte enables, active low |
| legacy_force_n | input | 1 | Sideband forced-claim request, active low |
| devsel_n | output | 1 | Device select, active low |
| claim_stb | output | 1 | One-cycle claim indication to the memory path |
| claim_addr | output | 32 | Address captured in the address phase |
| claim_write | output | 1 | 1 when the claimed command is a memory write |
| claim_forced | output | 1 | 1 when the claim came from the sideband override |

## Verification
Two functions can act on the same address phase: the sideband override and the normal window decode. The bench provokes this with the pin low and an in-window address, and with the pin low and a non-memory command. A correct result is a single claim with claim_forced set in the first case and no claim in the second. The bench also drives the pin low only during data phases, to show that the override is sampled at the address edge alone. Early returns to idle are timed against both decision edges.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC1,
    ST_DEC2,
    ST_CLAIM,
    ST_BUSY
  } phase_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  function automatic logic is_mem_cmd(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  endfunction

endpackage

// File: rtl/mcd_addr_latch.sv
module mcd_addr_latch #(
  parameter int ADDR_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] ad,
  input  logic [CBE_W-1:0]  cbe_n,
  input  logic              force_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CBE_W-1:0]  cmd_q,
  output logic              forced_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cmd_q    <= '0;
      forced_q <= 1'b0;
    end else if (cap) begin
      addr_q   <= ad;
      cmd_q    <= cbe_n;
      forced_q <= ~force_n;
    end
  end

endmodule

// File: rtl/mcd_window_decode.sv
module mcd_window_decode
  import mcd_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                CBE_W    = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [CBE_W-1:0]  cmd_q,
  input  logic              forced_q,
  output logic              hit_q
);

  logic cmd_ok;
  logic in_win;
  logic hit_d;

  always_comb begin
    cmd_ok = is_mem_cmd(cmd_q);
    in_win = ((addr_q & WIN_MASK) == WIN_BASE);
    hit_d  = cmd_ok && (forced_q || in_win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hit_q <= 1'b0;
    else if (eval)  hit_q <= hit_d;
  end

endmodule

// File: rtl/mcd_phase_fsm.sv
module mcd_phase_fsm
  import mcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic hit_q,
  output logic cap,
  output logic eval,
  output logic devsel_n,
  output logic claim_stb
);

  phase_e state;
  logic   bus_idle;

  always_comb begin
    bus_idle = frame_n && irdy_n;
    cap      = (state == ST_IDLE) && !frame_n;
    eval     = (state == ST_DEC1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      devsel_n  <= 1'b1;
      claim_stb <= 1'b0;
    end else begin
      claim_stb <= 1'b0;
      unique case (state)
        ST_IDLE:  if (!frame_n) state <= ST_DEC1;
        ST_DEC1:  state <= bus_idle ? ST_IDLE : ST_DEC2;
        ST_DEC2: begin
          if (bus_idle) begin
            state <= ST_IDLE;
          end else if (hit_q) begin
            state     <= ST_CLAIM;
            devsel_n  <= 1'b0;
            claim_stb <= 1'b1;
          end else begin
            state <= ST_BUSY;
          end
        end
        ST_CLAIM: if (bus_idle) begin
          state    <= ST_IDLE;
          devsel_n <= 1'b1;
        end
        ST_BUSY:  if (bus_idle) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && frame_n && irdy_n) |=> devsel_n);

  assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |=> !claim_stb);

  assert_strobe_devsel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |-> !devsel_n);

endmodule

// File: rtl/mcd_claim_top.sv
module mcd_claim_top
  import mcd_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                CBE_W    = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] WIN_MASK = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic [CBE_W-1:0]  cbe_n,
  input  logic              legacy_force_n,
  output logic              devsel_n,
  output logic              claim_stb,
  output logic [ADDR_W-1:0] claim_addr,
  output logic              claim_write,
  output logic              claim_forced
);

  logic              cap;
  logic              eval;
  logic              hit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CBE_W-1:0]  cmd_q;
  logic              forced_q;

  mcd_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .hit_q     (hit_q),
    .cap       (cap),
    .eval      (eval),
    .devsel_n  (devsel_n),
    .claim_stb (claim_stb)
  );

  mcd_addr_latch #(.ADDR_W(ADDR_W), .CBE_W(CBE_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .ad       (ad),
    .cbe_n    (cbe_n),
    .force_n  (legacy_force_n),
    .addr_q   (addr_q),
    .cmd_q    (cmd_q),
    .forced_q (forced_q)
  );

  mcd_window_decode #(
    .ADDR_W(ADDR_W), .CBE_W(CBE_W), .WIN_BASE(WIN_BASE), .WIN_MASK(WIN_MASK)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .eval     (eval),
    .addr_q   (addr_q),
    .cmd_q    (cmd_q),
    .forced_q (forced_q),
    .hit_q    (hit_q)
  );

  assign claim_addr   = addr_q;
  assign claim_write  = cmd_q[0];
  assign claim_forced = forced_q;

  // Address phase is three sampled edges before the strobe is seen.
  assert_medium_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> ($past(frame_n, 3) == 1'b0));

  assert_cmd_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |-> is_mem_cmd($past(cbe_n, 3)));

  assert_addr_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    claim_stb |-> (claim_addr == $past(ad, 3)));

  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_stb && $past(legacy_force_n, 3)) |-> ((claim_addr & WIN_MASK) == WIN_BASE));

endmodule

// File: tb/mcd_claim_top_bench.sv
module mcd_claim_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        legacy_force_n = 1'b1;
  logic        devsel_n;
  logic        claim_stb;
  logic [31:0] claim_addr;
  logic        claim_write;
  logic        claim_forced;

  int n_checks = 0;
  int n_err    = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  mcd_claim_top u_mcd_claim_top (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad(ad), .cbe_n(cbe_n), .legacy_force_n(legacy_force_n),
    .devsel_n(devsel_n), .claim_stb(claim_stb), .claim_addr(claim_addr),
    .claim_write(claim_write), .claim_forced(claim_forced)
  );

  function automatic bit exp_hit(logic [31:0] a, logic [3:0] c, logic f_n, int d);
    bit mem = (c == 4'b0110) || (c == 4'b0111);
    return mem && (!f_n || a[31]) && (d >= 2);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive_step(int j, int d, bit late);
    ad    = $urandom;
    cbe_n = 4'($urandom);
    if (j <= d) begin
      frame_n        = (j < d) ? 1'b0 : 1'b1;
      irdy_n         = 1'b0;
      legacy_force_n = late ? 1'b0 : 1'b1;
    end else begin
      frame_n        = 1'b1;
      irdy_n         = 1'b1;
      legacy_force_n = 1'b1;
    end
  endtask

  task automatic run_txn(logic [31:0] a, logic [3:0] c, logic f_n, int d, bit late, string req);
    bit h = exp_hit(a, c, f_n, d);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = c; legacy_force_n = f_n;
    for (int i = 0; i <= d + 1; i++) begin
      @(negedge clk);
      begin
        bit ed = h && (i >= 2) && (i <= d);
        bit es = h && (i == 2);
        chk(devsel_n == !ed, (i == d + 1) ? "R7" : (i < 2 ? "R6" : req), "devsel_n",
            {31'b0, devsel_n}, {31'b0, !ed});
        chk(claim_stb == es, "R9", "claim_stb", {31'b0, claim_stb}, {31'b0, es});
        if (es) begin
          chk(claim_addr == a, "R9", "claim_addr", claim_addr, a);
          chk(claim_write == c[0], "R9", "claim_write", {31'b0, claim_write}, {31'b0, c[0]});
          chk(claim_forced == !f_n, "R4", "claim_forced", {31'b0, claim_forced}, {31'b0, !f_n});
        end
      end
      if (i <= d) drive_step(i + 1, d, late);
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(devsel_n == 1'b1, "R1", "devsel_n in reset", {31'b0, devsel_n}, 32'd1);
    chk(claim_stb == 1'b0, "R1", "claim_stb in reset", {31'b0, claim_stb}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(devsel_n == 1'b1, "R1", "devsel_n after reset", {31'b0, devsel_n}, 32'd1);

    run_txn(32'h8000_0000, 4'b0110, 1'b1, 3, 1'b0, "R2");
    run_txn(32'hFFFF_FFFF, 4'b0111, 1'b1, 2, 1'b0, "R2");
    run_txn(32'h7FFF_FFFF, 4'b0110, 1'b1, 3, 1'b0, "R3");
    run_txn(32'h0000_1000, 4'b0111, 1'b0, 4, 1'b0, "R4");
    run_txn(32'h9000_0000, 4'b0110, 1'b0, 2, 1'b0, "R4");
    run_txn(32'h0000_0040, 4'b0010, 1'b0, 3, 1'b0, "R5");
    run_txn(32'hC000_0000, 4'b1010, 1'b0, 3, 1'b0, "R5");
    run_txn(32'h1234_5678, 4'b0110, 1'b1, 5, 1'b1, "R8");
    run_txn(32'h8000_1000, 4'b0110, 1'b1, 0, 1'b0, "R10");
    run_txn(32'h0000_2000, 4'b0111, 1'b0, 1, 1'b0, "R10");
    run_txn(32'hA000_0000, 4'b0111, 1'b1, 8, 1'b0, "R7");

    for (int k = 0; k < 60; k++) begin
      logic [3:0]  c;
      int          sel = $urandom_range(0, 3);
      c = (sel == 0) ? 4'($urandom) : ((sel == 1) ? 4'b0110 : 4'b0111);
      run_txn($urandom, c, 1'($urandom_range(0, 1)), $urandom_range(0, 6),
              1'($urandom_range(0, 1)), "R2");
      for (int g = 0; g < $urandom_range(0, 2); g++) begin
        @(negedge clk);
        chk(devsel_n == 1'b1, "R7", "devsel_n idle gap", {31'b0, devsel_n}, 32'd1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule